// File: doc/BRIEF.md
# Banked Predicate Register File

This block stores the one-bit qualifying predicates of a dual-issue core. The storage is split into sixteen banks of eight predicates, and only one bank, chosen by a bank-select register, is visible to instructions at a time. Each of the two issue slots presents a 3-bit predicate index and receives the addressed bit of the visible bank, which decides whether that slot's instruction takes effect.

Compare instructions of both slots write their result pairs through four independent single-bit write ports aimed at the visible bank. A bank-load write port replaces all eight predicates of any named bank in one cycle. The bank-switch instruction loads the bank-select register during decode. Predicate 0 of every bank is tied true, so it serves as the "always" guard and as a sink for unwanted compare results. With the default write-through setting, a read returns the value the visible bank will hold after the current cycle's writes.

Top module: `pred_regfile`

## Requirements
- R1: After reset, bank 0 is visible and every predicate of every bank other than index 0 reads 0.
- R2: Predicate index 0 of every bank always reads 1; bit writes and bank-load writes to it have no effect.
- R3: A bit write with enable high, index i and value v sets predicate i of the visible bank to v, and reads in later cycles return v.
- R4: All four bit write ports act in the same cycle on distinct indices without disturbing each other.
- R5: When several enabled bit write ports name the same index in one cycle, the value from the highest-numbered port (port 3 over 2 over 1 over 0) is stored.
- R6: A bank-load write with bank number b and data d stores bit k of d into predicate k of bank b, for k from 1 to 7, whether or not b is visible.
- R7: When a bank-load write targets the visible bank in the same cycle as bit writes, the bit writes take precedence on the indices they name.
- R8: A bank-select update with value b makes bank b visible from the next cycle; reads and bit writes in the update cycle still use the previously visible bank.
- R9: With write-through enabled, a read of index i in the same cycle as a write to predicate i of the visible bank returns the newly written value.
- R10: Writes to the visible bank leave every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 6 | Two 3-bit predicate indices, slot 0 in bits 2:0, slot 1 in bits 5:3 |
| rd_val | output | 2 | Predicate bit read for slot 0 (bit 0) and slot 1 (bit 1) |
| bw_en | input | 4 | Enable of each bit write port, port p in bit p |
| bw_idx | input | 12 | 3-bit index of each bit write port, port p in bits 3p+2:3p |
| bw_val | input | 4 | Value of each bit write port, port p in bit p |
| byte_en | input | 1 | Bank-load write enable |
| byte_bank | input | 4 | Bank number loaded by the bank-load write |
| byte_data | input | 8 | Predicate values for the bank, predicate k in bit k |
| bsel_en | input | 1 | Bank-select update enable |
| bsel_val | input | 4 | New bank-select value |

## Verification
A corrupt bank-select value shows on both read ports in the very next cycle as a whole set of predicates that do not match what was last written, so every read after a switch is compared. A bit of stored state that flips or a write that lands in the wrong bank stays hidden until that bank becomes visible and the index is read, so the stimulus returns to earlier banks and sweeps indices after switches. Port priority and bank-load ordering faults show in the cycle of the write itself through write-through, and again one cycle later from storage.

// File: rtl/pred_pkg.sv
package pred_pkg;
    localparam int NUM_BANKS    = 16;
    localparam int PREDS        = 8;
    localparam int BIT_WR_PORTS = 4;
    localparam int RD_PORTS     = 2;
    localparam int BANK_W       = $clog2(NUM_BANKS);
    localparam int IDX_W        = $clog2(PREDS);

    typedef logic [IDX_W-1:0]  pidx_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [PREDS-1:0]  bank_bits_t;

    typedef struct packed {
        logic  en;
        pidx_t idx;
        logic  val;
    } bitwr_t;

    typedef struct packed {
        logic       en;
        bank_t      bank;
        bank_bits_t data;
    } bytewr_t;

    localparam bank_bits_t BANK_RESET = bank_bits_t'(1);

    function automatic bank_bits_t force_p0(input bank_bits_t b);
        bank_bits_t r;
        r    = b;
        r[0] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pred_bank_sel.sv
module pred_bank_sel
    import pred_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  upd_en,
    input  bank_t upd_val,
    output bank_t sel
);
    always_ff @(posedge clk) begin
        if (rst)
            sel <= '0;
        else if (upd_en)
            sel <= upd_val;
    end

    assert_sel_load_R8: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> sel == $past(upd_val));

    assert_sel_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(sel));
endmodule

// File: rtl/pred_bank.sv
module pred_bank
    import pred_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  bank_t      act,
    input  bytewr_t    byte_wr,
    input  bitwr_t     bit_wr [BIT_WR_PORTS],
    output bank_bits_t cur,
    output bank_bits_t nxt
);
    localparam bank_t MY_ID  = bank_t'(BANK_ID);
    localparam int    TOP_P  = BIT_WR_PORTS - 1;

    logic visible;
    logic byte_hit;
    logic any_bit;

    always_comb begin
        visible  = (act == MY_ID);
        byte_hit = byte_wr.en && (byte_wr.bank == MY_ID);
        any_bit  = 1'b0;
        for (int p = 0; p < BIT_WR_PORTS; p++)
            any_bit = any_bit | bit_wr[p].en;
    end

    // bank load first, then bit ports in ascending order (last one wins)
    always_comb begin
        nxt = cur;
        if (byte_hit)
            nxt = byte_wr.data;
        if (visible) begin
            for (int p = 0; p < BIT_WR_PORTS; p++)
                if (bit_wr[p].en)
                    nxt[bit_wr[p].idx] = bit_wr[p].val;
        end
        nxt = force_p0(nxt);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= BANK_RESET;
        else
            cur <= nxt;
    end

    assert_reset_value_R1: assert property (@(posedge clk)
        $past(rst) |-> cur == BANK_RESET);

    assert_bank_load_R6: assert property (@(posedge clk) disable iff (rst)
        (byte_hit && !visible) |=> cur == force_p0($past(byte_wr.data)));

    assert_top_port_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (visible && bit_wr[TOP_P].en && bit_wr[TOP_P].idx != '0)
        |=> cur[$past(bit_wr[TOP_P].idx)] == $past(bit_wr[TOP_P].val));

    assert_untouched_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!byte_hit && !(visible && any_bit)) |=> $stable(cur));
endmodule

// File: rtl/pred_read_port.sv
module pred_read_port
    import pred_pkg::*;
#(
    parameter bit WRITE_THROUGH = 1'b1
) (
    input  bank_bits_t cur_act,
    input  bank_bits_t nxt_act,
    input  pidx_t      idx,
    output logic       val
);
    generate
        if (WRITE_THROUGH) begin : g_through
            assign val = nxt_act[idx];
        end else begin : g_stored
            assign val = cur_act[idx];
        end
    endgenerate
endmodule

// File: rtl/pred_regfile.sv
module pred_regfile
    import pred_pkg::*;
#(
    parameter bit WRITE_THROUGH = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [RD_PORTS*IDX_W-1:0]   rd_idx,
    output logic [RD_PORTS-1:0]         rd_val,
    input  logic [BIT_WR_PORTS-1:0]     bw_en,
    input  logic [BIT_WR_PORTS*IDX_W-1:0] bw_idx,
    input  logic [BIT_WR_PORTS-1:0]     bw_val,
    input  logic                        byte_en,
    input  logic [BANK_W-1:0]           byte_bank,
    input  logic [PREDS-1:0]            byte_data,
    input  logic                        bsel_en,
    input  logic [BANK_W-1:0]           bsel_val
);
    bank_t      act;
    bitwr_t     bit_wr [BIT_WR_PORTS];
    bytewr_t    byte_wr;
    bank_bits_t bank_cur [NUM_BANKS];
    bank_bits_t bank_nxt [NUM_BANKS];
    bank_bits_t cur_act;
    bank_bits_t nxt_act;

    generate
        for (genvar p = 0; p < BIT_WR_PORTS; p++) begin : g_wr
            assign bit_wr[p].en  = bw_en[p];
            assign bit_wr[p].idx = bw_idx[p*IDX_W +: IDX_W];
            assign bit_wr[p].val = bw_val[p];
        end
    endgenerate

    assign byte_wr.en   = byte_en;
    assign byte_wr.bank = byte_bank;
    assign byte_wr.data = byte_data;

    pred_bank_sel u_sel (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (bsel_en),
        .upd_val (bsel_val),
        .sel     (act)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            pred_bank #(.BANK_ID(b)) u_bank (
                .clk     (clk),
                .rst     (rst),
                .act     (act),
                .byte_wr (byte_wr),
                .bit_wr  (bit_wr),
                .cur     (bank_cur[b]),
                .nxt     (bank_nxt[b])
            );
        end
    endgenerate

    assign cur_act = bank_cur[act];
    assign nxt_act = bank_nxt[act];

    generate
        for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
            pred_read_port #(.WRITE_THROUGH(WRITE_THROUGH)) u_rd (
                .cur_act (cur_act),
                .nxt_act (nxt_act),
                .idx     (rd_idx[r*IDX_W +: IDX_W]),
                .val     (rd_val[r])
            );

            assert_always_true_R2: assert property (@(posedge clk) disable iff (rst)
                (rd_idx[r*IDX_W +: IDX_W] == '0) |-> rd_val[r]);
        end
    endgenerate
endmodule

// File: tb/pred_regfile_bench.sv
module pred_regfile_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  rd_idx = '0;
    logic [1:0]  rd_val;
    logic [3:0]  bw_en = '0;
    logic [11:0] bw_idx = '0;
    logic [3:0]  bw_val = '0;
    logic        byte_en = 1'b0;
    logic [3:0]  byte_bank = '0;
    logic [7:0]  byte_data = '0;
    logic        bsel_en = 1'b0;
    logic [3:0]  bsel_val = '0;

    int checks = 0;
    int fails  = 0;

    bit [7:0] m [16];
    int       bank;

    always #2 clk = ~clk;

    pred_regfile u_pred_regfile (
        .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_val(rd_val),
        .bw_en(bw_en), .bw_idx(bw_idx), .bw_val(bw_val),
        .byte_en(byte_en), .byte_bank(byte_bank), .byte_data(byte_data),
        .bsel_en(bsel_en), .bsel_val(bsel_val)
    );

    function automatic bit [7:0] next_visible();
        bit [7:0] t;
        t = m[bank];
        if (byte_en && int'(byte_bank) == bank) t = byte_data;
        for (int p = 0; p < 4; p++)
            if (bw_en[p]) t[bw_idx[p*3 +: 3]] = bw_val[p];
        t[0] = 1'b1;
        return t;
    endfunction

    task automatic set_rd(input int a, input int b);
        rd_idx[2:0] = 3'(a);
        rd_idx[5:3] = 3'(b);
    endtask

    task automatic set_bw(input int p, input int idx, input bit v);
        bw_en[p] = 1'b1;
        bw_idx[p*3 +: 3] = 3'(idx);
        bw_val[p] = v;
    endtask

    // compare both read ports, advance one clock, update the model
    task automatic tick(input string tag);
        bit [7:0] t;
        #1;
        t = next_visible();
        for (int r = 0; r < 2; r++) begin
            checks++;
            if (rd_val[r] !== t[rd_idx[r*3 +: 3]]) begin
                fails++;
                $display("FAIL %s port %0d idx %0d bank %0d actual=%b expected=%b",
                         tag, r, rd_idx[r*3 +: 3], bank, rd_val[r], t[rd_idx[r*3 +: 3]]);
            end
        end
        @(posedge clk);
        if (byte_en) m[byte_bank] = byte_data | 8'h01;
        m[bank] = t;
        if (bsel_en) bank = int'(bsel_val);
        @(negedge clk);
        bw_en = '0;
        byte_en = 1'b0;
        bsel_en = 1'b0;
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 4; i++) begin
            set_rd(i, 7 - i);
            tick(tag);
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int b = 0; b < 16; b++) m[b] = 8'h01;
        bank = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset contents of bank 0 and of bank 5
        sweep("R1");
        bsel_en = 1'b1; bsel_val = 4'd5; tick("R8");
        sweep("R1");
        bsel_en = 1'b1; bsel_val = 4'd0; tick("R8");

        // R3 single bit write, read back next cycles
        set_bw(0, 3, 1'b1); set_rd(1, 2); tick("R3");
        set_rd(3, 3); tick("R3");

        // R9 same-cycle write-through
        set_bw(1, 5, 1'b1); set_rd(5, 4); tick("R9");
        set_bw(2, 5, 1'b0); set_rd(6, 5); tick("R9");

        // R2 writes to predicate 0 ignored
        set_bw(0, 0, 1'b0); set_bw(3, 0, 1'b0);
        byte_en = 1'b1; byte_bank = 4'd0; byte_data = 8'h00;
        set_rd(0, 0); tick("R2");
        set_rd(0, 1); tick("R2");

        // R4 four distinct writes
        set_bw(0, 1, 1'b1); set_bw(1, 2, 1'b0); set_bw(2, 4, 1'b1); set_bw(3, 6, 1'b1);
        set_rd(1, 4); tick("R4");
        sweep("R4");

        // R5 conflicting writes, highest port wins
        set_bw(0, 7, 1'b1); set_bw(1, 7, 1'b0); set_bw(2, 7, 1'b0); set_bw(3, 7, 1'b1);
        set_rd(7, 1); tick("R5");
        set_rd(7, 7); tick("R5");
        set_bw(0, 7, 1'b1); set_bw(1, 7, 1'b0); set_bw(2, 7, 1'b1); set_bw(3, 7, 1'b0);
        set_rd(7, 6); tick("R5");
        set_bw(0, 2, 1'b0); set_bw(1, 2, 1'b1);
        set_rd(2, 7); tick("R5");

        // R6 load a hidden bank, then view it
        byte_en = 1'b1; byte_bank = 4'd9; byte_data = 8'hA6;
        set_rd(1, 2); tick("R6");
        bsel_en = 1'b1; bsel_val = 4'd9; set_rd(2, 4); tick("R8");
        sweep("R6");

        // R7 bank load of visible bank plus bit write
        byte_en = 1'b1; byte_bank = 4'd9; byte_data = 8'hFF;
        set_bw(1, 2, 1'b0); set_rd(2, 3); tick("R7");
        sweep("R7");

        // R8 bit write in switch cycle goes to old bank
        bsel_en = 1'b1; bsel_val = 4'd3; set_bw(0, 4, 1'b0); set_rd(4, 5); tick("R8");
        set_rd(4, 5); tick("R8");
        set_bw(0, 6, 1'b1); set_rd(6, 1); tick("R8");

        // R10 other banks untouched
        bsel_en = 1'b1; bsel_val = 4'd9; tick("R10");
        sweep("R10");
        bsel_en = 1'b1; bsel_val = 4'd0; tick("R10");
        sweep("R10");

        // mixed random traffic against the model (R5 ordering included)
        for (int n = 0; n < 400; n++) begin
            bw_en   = 4'($urandom);
            bw_idx  = 12'($urandom);
            bw_val  = 4'($urandom);
            byte_en = ($urandom % 5) == 0;
            byte_bank = 4'($urandom % 4);
            byte_data = 8'($urandom);
            bsel_en = ($urandom % 6) == 0;
            bsel_val = 4'($urandom % 4);
            rd_idx  = 6'($urandom);
            tick("R5");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule